// File: doc/BRIEF.md
# Bus Cycle Output Drive Controller

This block launches bus cycles for a processor on a pipelined burst bus and decides, clock by clock, whether each group of bus outputs is driven or floated. The core raises a cycle request together with the cycle's attributes: write or read, memory or I/O, data or code, locked, burst or single, address and byte enables. When the bus is free to start a cycle, the block pulses the address strobe for one clock and registers the attributes on that same edge. The attributes then stay where they are until a later strobe.

The block counts ready inputs to find the final transfer of each cycle. A burst needs four readies and a single transfer needs one. A next-address input ends the attribute phase early, so a second cycle can be launched while readies for the first one are still owed. Readies are always credited to the older cycle first.

There are three output groups. The control group (strobe, attributes, byte enables, lock) floats on backoff and on hold-acknowledge. The address group floats on those two and also on address-hold. The status group (hold-acknowledge) floats only in tri-state test mode, which floats all three groups. A separate voltage-detect output is always driven low. A cycle that backoff cuts short is issued again from its start as soon as the bus is released.

Top module: `bus_cycle_drive`

## Requirements
- R1: While reset is asserted, the strobe and hold-acknowledge are 0, all attribute, address and byte-enable outputs are 0, and all three output-enable signals are 1.
- R2: A request is launched on a clock edge only when all of the following hold: no cycle is holding its attributes, backoff, hold, address-hold and tri-state test are all low, and hold-acknowledge is low. On launch, the strobe is 1 for exactly the following clock, and the control and address groups are enabled during that clock.
- R3: The attribute, lock, address and byte-enable outputs change only in a clock where the strobe is 1, and show the values the core presented on the launch edge.
- R4: With the burst flag at 1 a cycle ends on its fourth sampled ready; with it at 0 it ends on its first. No new strobe is issued before that edge, and a waiting request can be launched on the following edge.
- R5: Next-address sampled high, with a cycle holding its attributes and no earlier cycle still owed readies, releases the attributes at that edge. The cycle's remaining readies are still counted, and a new cycle may launch on the next edge. Next-address is ignored while an earlier cycle is still owed readies.
- R6: While two cycles are outstanding, each ready is credited to the older one. The newer cycle's count starts only after the older one is complete.
- R7: Backoff sampled high floats the control and address groups from the next clock. It abandons every outstanding cycle, and readies sampled while it is high are ignored.
- R8: A cycle that was holding its attributes when backoff hit is issued again with the same attributes and the full ready count. This happens on the first edge at which the launch conditions of R2 hold again, and it takes precedence over a new request.
- R9: Hold sampled high with no cycle outstanding sets hold-acknowledge from the next clock. While hold-acknowledge is 1, the control and address groups float and no cycle is launched. Hold-acknowledge clears, and the groups are driven again, from the clock after hold is sampled low.
- R10: Address-hold sampled high floats only the address group from the next clock. The cycle in progress keeps counting readies.
- R11: Tri-state test sampled high floats all three groups from the next clock and blocks launches.
- R12: The voltage-detect output is always 0. The status group is enabled in every clock that follows an edge at which tri-state test was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_req | input | 1 | Core requests a cycle (held until the strobe is seen) |
| req_wr | input | 1 | Requested cycle is a write |
| req_mio | input | 1 | Requested cycle targets memory (1) or I/O (0) |
| req_dc | input | 1 | Requested cycle is data (1) or code (0) |
| req_lock | input | 1 | Requested cycle is locked |
| req_burst | input | 1 | Requested cycle is a four-transfer burst |
| req_addr | input | ADDR_W | Requested address |
| req_be | input | BE_W | Requested byte enables |
| bus_brdy | input | 1 | Burst ready from the system |
| bus_na | input | 1 | Next-address request from the system |
| bus_boff | input | 1 | Backoff |
| bus_hold | input | 1 | Bus hold request |
| bus_ahold | input | 1 | Address hold |
| tri_test | input | 1 | Tri-state test mode |
| bus_ads | output | 1 | Address strobe |
| bus_wr | output | 1 | Write/read attribute |
| bus_mio | output | 1 | Memory/IO attribute |
| bus_dc | output | 1 | Data/code attribute |
| bus_lock | output | 1 | Lock attribute |
| bus_addr | output | ADDR_W | Address |
| bus_be | output | BE_W | Byte enables |
| bus_hlda | output | 1 | Hold acknowledge |
| ctl_oe | output | 1 | Drive enable of the control group |
| adr_oe | output | 1 | Drive enable of the address group |
| sts_oe | output | 1 | Drive enable of the status group |
| vdet | output | 1 | Voltage-detect output, constant 0 |

## Verification
The hardest state to reach is backoff landing while a pipelined pair is outstanding: an older cycle released by next-address that is still owed readies, and a newer cycle holding its attributes. The stimulus builds this pair by asserting next-address in the middle of a burst and raising a fresh request at once. It then asserts backoff while readies are still arriving, and keeps a competing request waiting while backoff is released. This shows that only the attribute-holding cycle is reissued, that it is reissued ahead of the waiting request, and that the abandoned readies are not counted.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

    // cycle attributes carried from the launch edge to the pins
    typedef struct packed {
        logic wr;
        logic mio;
        logic dc;
        logic lock;
        logic burst;
    } attr_t;

    // registered pin-drive state
    typedef struct packed {
        logic hlda;
        logic ctl_oe;
        logic adr_oe;
        logic sts_oe;
    } drive_t;

endpackage

// File: rtl/bcd_ready_track.sv
module bcd_ready_track #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_len,
    input  logic             brdy,
    input  logic             na,
    input  logic             boff,
    output logic             held_busy,
    output logic             tail_busy,
    output logic             aborted
);

    typedef struct packed {
        logic [CNT_W-1:0] cur;   // readies owed by the attribute-holding cycle
        logic [CNT_W-1:0] tail;  // readies owed by a cycle released early
    } trk_t;

    trk_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        aborted = boff && (st_q.cur != '0);
        if (boff) begin
            st_d.cur  = '0;
            st_d.tail = '0;
        end else begin
            if (brdy) begin
                if (st_q.tail != '0) begin
                    st_d.tail = st_q.tail - 1'b1;
                end else if (st_q.cur != '0) begin
                    st_d.cur = st_q.cur - 1'b1;
                end
            end
            if (na && (st_q.tail == '0) && (st_q.cur != '0) && (st_d.cur != '0)) begin
                st_d.tail = st_d.cur;
                st_d.cur  = '0;
            end
            if (load) begin
                st_d.cur = load_len;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_busy = (st_q.cur != '0);
    assign tail_busy = (st_q.tail != '0);

endmodule

// File: rtl/bcd_float_ctl.sv
module bcd_float_ctl (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             boff,
    input  logic             ahold,
    input  logic             tmode,
    input  logic             bus_free,
    output bcd_pkg::drive_t  drv_o
);

    bcd_pkg::drive_t drv_d, drv_q;

    always_comb begin
        drv_d.hlda   = hold && bus_free;
        drv_d.ctl_oe = !(tmode || boff || drv_d.hlda);
        drv_d.adr_oe = drv_d.ctl_oe && !ahold;
        drv_d.sts_oe = !tmode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q <= '{hlda: 1'b0, ctl_oe: 1'b1, adr_oe: 1'b1, sts_oe: 1'b1};
        end else begin
            drv_q <= drv_d;
        end
    end

    assign drv_o = drv_q;

endmodule

// File: rtl/bus_cycle_drive.sv
module bus_cycle_drive #(
    parameter int ADDR_W    = 29,
    parameter int BE_W      = 8,
    parameter int BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_req,
    input  logic              req_wr,
    input  logic              req_mio,
    input  logic              req_dc,
    input  logic              req_lock,
    input  logic              req_burst,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic              bus_brdy,
    input  logic              bus_na,
    input  logic              bus_boff,
    input  logic              bus_hold,
    input  logic              bus_ahold,
    input  logic              tri_test,
    output logic              bus_ads,
    output logic              bus_wr,
    output logic              bus_mio,
    output logic              bus_dc,
    output logic              bus_lock,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [BE_W-1:0]   bus_be,
    output logic              bus_hlda,
    output logic              ctl_oe,
    output logic              adr_oe,
    output logic              sts_oe,
    output logic              vdet
);

    localparam int CNT_W = $clog2(BURST_LEN + 1);

    typedef struct packed {
        logic              ads;
        logic              restart;
        bcd_pkg::attr_t    attr;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
    } cyc_st_t;

    cyc_st_t          s_d, s_q;
    bcd_pkg::drive_t  drv_q;
    logic             held_busy, tail_busy, aborted;
    logic             launch, use_burst;
    logic [CNT_W-1:0] load_len;

    bcd_ready_track #(.CNT_W(CNT_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (launch),
        .load_len  (load_len),
        .brdy      (bus_brdy),
        .na        (bus_na),
        .boff      (bus_boff),
        .held_busy (held_busy),
        .tail_busy (tail_busy),
        .aborted   (aborted)
    );

    bcd_float_ctl u_flt (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (bus_hold),
        .boff     (bus_boff),
        .ahold    (bus_ahold),
        .tmode    (tri_test),
        .bus_free (!held_busy && !tail_busy),
        .drv_o    (drv_q)
    );

    always_comb begin
        launch    = !held_busy && (cyc_req || s_q.restart) && !bus_boff && !bus_hold
                    && !drv_q.hlda && !bus_ahold && !tri_test;
        use_burst = s_q.restart ? s_q.attr.burst : req_burst;
        load_len  = use_burst ? CNT_W'(BURST_LEN) : CNT_W'(1);

        s_d     = s_q;
        s_d.ads = launch;
        if (aborted) begin
            s_d.restart = 1'b1;
        end
        if (launch) begin
            s_d.restart = 1'b0;
            if (!s_q.restart) begin
                s_d.attr.wr    = req_wr;
                s_d.attr.mio   = req_mio;
                s_d.attr.dc    = req_dc;
                s_d.attr.lock  = req_lock;
                s_d.attr.burst = req_burst;
                s_d.addr       = req_addr;
                s_d.be         = req_be;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_ads  = s_q.ads;
    assign bus_wr   = s_q.attr.wr;
    assign bus_mio  = s_q.attr.mio;
    assign bus_dc   = s_q.attr.dc;
    assign bus_lock = s_q.attr.lock;
    assign bus_addr = s_q.addr;
    assign bus_be   = s_q.be;
    assign bus_hlda = drv_q.hlda;
    assign ctl_oe   = drv_q.ctl_oe;
    assign adr_oe   = drv_q.adr_oe;
    assign sts_oe   = drv_q.sts_oe;
    assign vdet     = 1'b0;

endmodule

// File: rtl/bcd_chk.sv
module bcd_chk #(
    parameter int ADDR_W = 29,
    parameter int BE_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_boff,
    input logic              bus_ahold,
    input logic              tri_test,
    input logic              bus_ads,
    input logic              bus_wr,
    input logic              bus_mio,
    input logic              bus_dc,
    input logic              bus_lock,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BE_W-1:0]   bus_be,
    input logic              bus_hlda,
    input logic              ctl_oe,
    input logic              adr_oe,
    input logic              sts_oe
);

    // R2
    ads_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ads |=> !bus_ads);

    // R2
    ads_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ads |-> (ctl_oe && adr_oe));

    // R3
    attr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ads |-> $stable({bus_wr, bus_mio, bus_dc, bus_lock, bus_addr, bus_be}));

    // R7
    boff_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_boff |=> (!ctl_oe && !adr_oe));

    // R9
    hlda_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hlda |-> (!ctl_oe && !adr_oe));

    // R9
    hlda_nolaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hlda |=> !bus_ads);

    // R10
    ahold_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ahold |=> !adr_oe);

    // R11
    test_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tri_test |=> (!sts_oe && !ctl_oe && !adr_oe));

    // R12
    sts_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tri_test |=> sts_oe);

endmodule

bind bus_cycle_drive bcd_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_boff  (bus_boff),
    .bus_ahold (bus_ahold),
    .tri_test  (tri_test),
    .bus_ads   (bus_ads),
    .bus_wr    (bus_wr),
    .bus_mio   (bus_mio),
    .bus_dc    (bus_dc),
    .bus_lock  (bus_lock),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_hlda  (bus_hlda),
    .ctl_oe    (ctl_oe),
    .adr_oe    (adr_oe),
    .sts_oe    (sts_oe)
);

// File: tb/sim_bus_cycle_drive.sv
`timescale 1ns/100ps
module sim_bus_cycle_drive;

    localparam int AW = 29;
    localparam int BW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cyc_req = 0, req_wr = 0, req_mio = 0, req_dc = 0, req_lock = 0, req_burst = 0;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_be = '0;
    logic brdy = 0, na = 0, boff = 0, hold = 0, ahold = 0, tmode = 0;
    logic ads, wr, mio, dc, lock, hlda, c_oe, a_oe, s_oe, vd;
    logic [AW-1:0] addr;
    logic [BW-1:0] be;

    int n_chk = 0;
    int n_bad = 0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    bus_cycle_drive u0 (
        .clk(clk), .rst_n(rst_n), .cyc_req(cyc_req), .req_wr(req_wr), .req_mio(req_mio),
        .req_dc(req_dc), .req_lock(req_lock), .req_burst(req_burst), .req_addr(req_addr),
        .req_be(req_be), .bus_brdy(brdy), .bus_na(na), .bus_boff(boff), .bus_hold(hold),
        .bus_ahold(ahold), .tri_test(tmode), .bus_ads(ads), .bus_wr(wr), .bus_mio(mio),
        .bus_dc(dc), .bus_lock(lock), .bus_addr(addr), .bus_be(be), .bus_hlda(hlda),
        .ctl_oe(c_oe), .adr_oe(a_oe), .sts_oe(s_oe), .vdet(vd)
    );

    // behavioural reference: queue of readies still owed, oldest first
    int   owed[$];
    bit   m_held, m_restart, m_ads, m_hlda, m_coe, m_aoe, m_soe;
    bit   m_wr, m_mio, m_dc, m_lock, m_burst;
    logic [AW-1:0] m_addr;
    logic [BW-1:0] m_be;

    always @(posedge clk) begin
        bit go, hl, held, rs;
        int nq, len;
        if (!rst_n) begin
            owed.delete();
            m_held = 0; m_restart = 0; m_ads = 0; m_hlda = 0;
            m_coe = 1; m_aoe = 1; m_soe = 1;
            m_wr = 0; m_mio = 0; m_dc = 0; m_lock = 0; m_burst = 0; m_addr = '0; m_be = '0;
        end else begin
            held = m_held; hl = m_hlda; rs = m_restart; nq = owed.size();
            go = !held && (cyc_req || rs) && !boff && !hold && !hl && !ahold && !tmode;
            if (boff) begin
                if (held) m_restart = 1;
                owed.delete();
                m_held = 0;
            end else begin
                if (brdy && nq > 0) begin
                    owed[0] = owed[0] - 1;
                    if (owed[0] == 0) begin
                        owed.pop_front();
                        if (owed.size() == 0) m_held = 0;
                    end
                end
                if (na && held && nq == 1 && owed.size() == 1) m_held = 0;
                if (go) begin
                    len = (rs ? m_burst : req_burst) ? 4 : 1;
                    owed.push_back(len);
                    m_held = 1;
                    if (!rs) begin
                        m_wr = req_wr; m_mio = req_mio; m_dc = req_dc; m_lock = req_lock;
                        m_burst = req_burst; m_addr = req_addr; m_be = req_be;
                    end
                    m_restart = 0;
                end
            end
            m_ads  = go;
            m_hlda = hold && (nq == 0);
            m_coe  = !(tmode || boff || m_hlda);
            m_aoe  = m_coe && !ahold;
            m_soe  = !tmode;
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(tag, "ads", 64'(ads), 64'(m_ads));
            chk(tag, "attrs", 64'({wr, mio, dc, lock}), 64'({m_wr, m_mio, m_dc, m_lock}));
            chk(tag, "addr", 64'(addr), 64'(m_addr));
            chk(tag, "be", 64'(be), 64'(m_be));
            chk(tag, "hlda", 64'(hlda), 64'(m_hlda));
            chk(tag, "ctl_oe", 64'(c_oe), 64'(m_coe));
            chk(tag, "adr_oe", 64'(a_oe), 64'(m_aoe));
            chk(tag, "sts_oe", 64'(s_oe), 64'(m_soe));
            chk("R12", "vdet", 64'(vd), 64'(0));
        end
    end

    // one clock of bus inputs; drops the core request once a strobe is seen
    task automatic step(bit b, bit n, bit bo, bit h, bit ah, bit t);
        @(posedge clk);
        #1;
        if (ads) cyc_req = 0;
        brdy = b; na = n; boff = bo; hold = h; ahold = ah; tmode = t;
    endtask

    task automatic idle(int k);
        for (int i = 0; i < k; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic request(bit w, bit m, bit d, bit l, bit bu, logic [AW-1:0] a, logic [BW-1:0] e);
        req_wr = w; req_mio = m; req_dc = d; req_lock = l; req_burst = bu;
        req_addr = a; req_be = e; cyc_req = 1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "ads", 64'(ads), 0);
        chk("R1", "hlda", 64'(hlda), 0);
        chk("R1", "oe", 64'({c_oe, a_oe, s_oe}), 64'(3'b111));
        chk("R1", "addr", 64'(addr), 0);
        chk("R1", "attrs", 64'({wr, mio, dc, lock}), 0);
        rst_n = 1;
        idle(2);

        tag = "R2";
        request(0, 1, 1, 0, 0, 29'h0123456, 8'hF0);
        idle(3); step(1, 0, 0, 0, 0, 0); idle(2);

        tag = "R3";
        request(1, 1, 1, 1, 0, 29'h1ABCDEF, 8'h0F);
        idle(2);
        req_wr = 0; req_addr = 29'h0000777; req_be = 8'hAA;   // changed while held
        idle(2); step(1, 0, 0, 0, 0, 0); idle(2);

        tag = "R4";
        request(0, 1, 0, 0, 1, 29'h0000100, 8'hFF);
        idle(1);
        request(1, 0, 1, 0, 0, 29'h0000200, 8'h01);          // waits behind the burst
        step(1, 0, 0, 0, 0, 0); step(0, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0); idle(1); step(1, 0, 0, 0, 0, 0); idle(3);
        step(1, 0, 0, 0, 0, 0); idle(2);

        tag = "R5";
        request(0, 1, 1, 0, 1, 29'h0000400, 8'hFF);
        idle(1); step(1, 0, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0);
        request(1, 1, 1, 0, 1, 29'h0000800, 8'h3C);
        idle(1); step(0, 1, 0, 0, 0, 0);                      // ignored: older still owed

        tag = "R6";
        step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0); step(1, 1, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0); idle(2);

        tag = "R7";
        request(0, 1, 1, 0, 1, 29'h0001000, 8'hFF);
        idle(1); step(1, 0, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0);
        request(1, 1, 0, 1, 1, 29'h0002000, 8'hC3);
        idle(1); step(1, 0, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0); step(1, 0, 1, 0, 0, 0);
        request(0, 0, 1, 0, 0, 29'h0003000, 8'h11);           // competes with the reissue

        tag = "R8";
        idle(2); step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0);
        step(1, 0, 0, 0, 0, 0); step(1, 0, 0, 0, 0, 0); idle(3);
        step(1, 0, 0, 0, 0, 0); idle(2);

        tag = "R9";
        request(1, 0, 1, 0, 0, 29'h0004000, 8'h02);
        idle(1); step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 1, 0, 0); step(1, 0, 0, 1, 0, 0);
        request(0, 1, 1, 0, 0, 29'h0005000, 8'h04);
        step(0, 0, 0, 1, 0, 0); step(0, 0, 0, 1, 0, 0); idle(3);
        step(1, 0, 0, 0, 0, 0); idle(2);

        tag = "R10";
        request(0, 1, 1, 0, 1, 29'h0006000, 8'hFF);
        idle(1); step(1, 0, 0, 0, 1, 0); step(1, 0, 0, 0, 1, 0);
        request(1, 1, 1, 0, 0, 29'h0007000, 8'h80);
        step(1, 0, 0, 0, 1, 0); step(1, 0, 0, 0, 1, 0); step(0, 0, 0, 0, 1, 0);
        idle(2); step(1, 0, 0, 0, 0, 0); idle(2);

        tag = "R11";
        step(0, 0, 0, 0, 0, 1);
        request(0, 1, 0, 0, 0, 29'h0008000, 8'h10);
        step(0, 0, 0, 0, 0, 1); step(0, 0, 0, 0, 0, 1); step(0, 0, 0, 1, 0, 1);
        idle(2); step(1, 0, 0, 0, 0, 0); idle(2);

        tag = "R12";
        step(0, 0, 0, 0, 1, 1); step(0, 0, 1, 0, 0, 0); idle(3);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule